// File: doc/BRIEF.md
# Character-Cell Phase Strobe Generator

This block splits a stream of pixel-rate clock enables into character cells of a fixed pixel width (eight by default) and decodes three single-cycle strobes from the position inside each cell. It runs on a fast system clock. The pixel rate is given by `pix_en`, which is high for one system-clock cycle per pixel.

The first strobe, `load_stb`, appears as the cell position enters zero. It tells the pixel serializer to take the next character byte. The second, `addr_adv_stb`, appears at position one and lets the display controller advance its memory address, because the byte from the previous cell has been captured by then. The third, `attr_load_stb`, appears at the last position of the cell, but only when `ctl_bit` is high. `ctl_bit` is the top bit of the current text byte. This strobe loads the per-character mode and attribute latch.

After reset the counter starts at zero. The address and attribute strobes stay silent until one complete cell has gone by. The block has no data stream of its own, so every pin is a plain control signal with no back-pressure.

Top module: `char_phase_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `cell_phase` is 0 and all three strobes are low.
- R2: `cell_phase` advances by one only on a clock edge where `pix_en` is high. It holds its value on every other edge.
- R3: After position CELL_PIX-1 (7 by default), the next enabled edge takes `cell_phase` back to 0, so one cell is exactly CELL_PIX pixels.
- R4: `load_stb` is high for exactly the one cycle after each enabled edge that takes the count from 7 to 0. This includes the first wrap after reset, so it fires once per cell.
- R5: `addr_adv_stb` is high for the one cycle after an enabled edge that takes the count from 0 to 1. This applies only once the count has wrapped at least once since reset.
- R6: `attr_load_stb` is high for the one cycle after an enabled edge that takes the count from 6 to 7. It needs `ctl_bit` high at that edge and at least one earlier wrap since reset.
- R7: Every strobe is one system-clock cycle wide, and no two strobes are high in the same cycle.
- R8: `ctl_bit` has no effect at any other position. `attr_load_stb` never rises while `ctl_bit` is high on enabled edges into positions other than 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | One-cycle pulse per pixel |
| ctl_bit | input | 1 | Top bit of the current text byte, qualifies the attribute strobe |
| cell_phase | output | 3 | Pixel position inside the current cell |
| load_stb | output | 1 | Character-load strobe at position 0 |
| addr_adv_stb | output | 1 | Address-advance strobe at position 1 |
| attr_load_stb | output | 1 | Mode/attribute latch strobe at position 7, qualified by `ctl_bit` |

## Verification
Every result sits one register behind the enabled edge that causes it. `cell_phase` and all three strobes take their new values at the same edge where `pix_en` is sampled high. `ctl_bit` matters only at that same edge. The bench drives its inputs on the falling edge and advances a behavioural model on the rising edge from those same stable inputs. It then compares every output on the next falling edge, which is half a cycle after the edge that produced it. The stimulus uses continuous enables, sparse enables, long enable gaps and a reset in mid-run, so the first-cell suppression and the wrap timing are both observed.

// File: rtl/cell_phase_pkg.sv
package cell_phase_pkg;
  parameter int CELL_PIX_DEF = 8;
  localparam int PH_W_DEF    = $clog2(CELL_PIX_DEF);
  localparam int NUM_STB     = 3;
  localparam int IDX_LOAD    = 0;
  localparam int IDX_ADV     = 1;
  localparam int IDX_ATTR    = 2;
endpackage

// File: rtl/cell_counter.sv
module cell_counter #(
  parameter int CELL_PIX = 8,
  localparam int PH_W    = $clog2(CELL_PIX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [PH_W-1:0] cnt,
  output logic            armed
);
  localparam logic [PH_W-1:0] LAST = PH_W'(CELL_PIX - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (step) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (cnt == LAST) armed <= 1'b1;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == LAST) |=> (cnt == '0));
  p_arm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

// File: rtl/phase_strobe.sv
module phase_strobe #(
  parameter int CELL_PIX = 8,
  parameter int FIRE_AT  = 0,
  localparam int PH_W    = $clog2(CELL_PIX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [PH_W-1:0] cnt,
  input  logic            arm,
  input  logic            qual,
  output logic            stb
);
  localparam logic [PH_W-1:0] PRE =
    PH_W'((FIRE_AT == 0) ? (CELL_PIX - 1) : (FIRE_AT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= 1'b0;
    else        stb <= step && arm && qual && (cnt == PRE);
  end

  p_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/char_phase_gen.sv
module char_phase_gen #(
  parameter int CELL_PIX   = cell_phase_pkg::CELL_PIX_DEF,
  parameter int ADV_PHASE  = 1,
  parameter int ATTR_PHASE = CELL_PIX - 1,
  localparam int PH_W      = $clog2(CELL_PIX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_en,
  input  logic            ctl_bit,
  output logic [PH_W-1:0] cell_phase,
  output logic            load_stb,
  output logic            addr_adv_stb,
  output logic            attr_load_stb
);
  import cell_phase_pkg::*;

  logic                armed;
  logic [NUM_STB-1:0]  stb_vec;

  cell_counter #(.CELL_PIX(CELL_PIX)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (pix_en),
    .cnt   (cell_phase),
    .armed (armed)
  );

  for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
    localparam int FIRE = (i == IDX_LOAD) ? 0 :
                          (i == IDX_ADV)  ? ADV_PHASE : ATTR_PHASE;
    logic arm_i, qual_i;
    assign arm_i  = (i == IDX_LOAD) ? 1'b1 : armed;
    assign qual_i = (i == IDX_ATTR) ? ctl_bit : 1'b1;
    phase_strobe #(.CELL_PIX(CELL_PIX), .FIRE_AT(FIRE)) u_ph (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_en),
      .cnt   (cell_phase),
      .arm   (arm_i),
      .qual  (qual_i),
      .stb   (stb_vec[i])
    );
  end

  assign load_stb      = stb_vec[IDX_LOAD];
  assign addr_adv_stb  = stb_vec[IDX_ADV];
  assign attr_load_stb = stb_vec[IDX_ATTR];

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_stb, addr_adv_stb, attr_load_stb}));
  p_load_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (cell_phase == '0));
  p_adv_at_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_adv_stb |-> (cell_phase == PH_W'(ADV_PHASE)));
  p_attr_at_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    attr_load_stb |-> (cell_phase == PH_W'(ATTR_PHASE)));
  p_attr_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attr_load_stb) |-> $past(ctl_bit));
endmodule

// File: tb/sim_char_phase_gen.sv
module sim_char_phase_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic ctl_bit = 1'b0;
  logic [2:0] cell_phase;
  logic load_stb, addr_adv_stb, attr_load_stb;

  int checks = 0;
  int failures = 0;

  int m_cnt = 0;
  bit m_arm = 0, m_ld = 0, m_adv = 0, m_attr = 0;
  bit run_cmp = 0;

  always #4 clk = ~clk;

  char_phase_gen u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .ctl_bit(ctl_bit),
    .cell_phase(cell_phase), .load_stb(load_stb),
    .addr_adv_stb(addr_adv_stb), .attr_load_stb(attr_load_stb)
  );

  // behavioural reference: cell position and first-wrap flag
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_arm <= 0; m_ld <= 0; m_adv <= 0; m_attr <= 0;
    end else begin
      m_ld   <= pix_en && (m_cnt == 7);
      m_adv  <= pix_en && m_arm && (m_cnt == 0);
      m_attr <= pix_en && m_arm && (m_cnt == 6) && ctl_bit;
      if (pix_en) begin
        m_cnt <= (m_cnt + 1) % 8;
        if (m_cnt == 7) m_arm <= 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R2/R3 phase", int'(cell_phase), m_cnt);
      chk("R4 load", int'(load_stb), int'(m_ld));
      chk("R5 adv", int'(addr_adv_stb), int'(m_adv));
      chk("R6/R8 attr", int'(attr_load_stb), int'(m_attr));
      chk("R7 exclusive", $countones({load_stb, addr_adv_stb, attr_load_stb}) <= 1, 1);
    end
  end

  task automatic tick(bit en, bit fl);
    @(negedge clk);
    pix_en = en;
    ctl_bit = fl;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk("R1 reset phase", int'(cell_phase), 0);
    chk("R1 reset strobes", int'({load_stb, addr_adv_stb, attr_load_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'({load_stb, addr_adv_stb, attr_load_stb}), 0);
    run_cmp = 1;
    // continuous enables, qualifier held high (R6, R8)
    for (int i = 0; i < 48; i++) tick(1, 1);
    // alternating qualifier
    for (int i = 0; i < 48; i++) tick(1, i[3]);
    // sparse enables, pseudo-random qualifier
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
      tick(lfsr[0] & lfsr[3], lfsr[5]);
    end
    // long gap: phase must hold (R2)
    for (int i = 0; i < 30; i++) tick(0, 1);
    // mid-run reset, then first cell must suppress adv/attr (R1, R5)
    @(negedge clk);
    run_cmp = 0;
    rst_n = 1'b0;
    pix_en = 1'b1;
    ctl_bit = 1'b1;
    @(negedge clk);
    chk("R1 mid reset", int'(cell_phase), 0);
    rst_n = 1'b1;
    run_cmp = 1;
    for (int i = 0; i < 40; i++) tick(1, 1);
    tick(0, 0);
    @(negedge clk);
    run_cmp = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule